// File: doc/BRIEF.md
# Banked Working-Register RAM with Bit Access and Hardware Stack

This block holds the 128-byte internal data memory of a small 8-bit controller core. The lowest 32 bytes double as four groups of eight working registers. Two bank-select inputs, driven from the core's status word, decide which group answers to register numbers 0 to 7. A byte port reaches any location in one of three ways: by an absolute address, by a working-register number, or through a pointer held in working register 0 or 1 of the active group.

A second port addresses single bits. Bit addresses below 80H land in the sixteen bytes from 20H to 2FH, and the port can read, set, clear or invert one bit there. Bit addresses from 80H up belong to the special-function area, which lives outside this block. For those the block only raises a flag and presents the aligned register address, so that the core can complete the access elsewhere. A hardware stack pointer grows upward through the same RAM and is driven by push and pop strobes.

Every strobe is taken in the cycle it is high. There is no back-pressure on any port. All read results are registered and appear one cycle after the request, holding the contents from before any write made in that cycle.

Top module: `iram_bank_bit`

## Requirements
- R1: After reset the stack pointer is 07H, and the overflow flag, SFR flag, bit read data, byte read data and pop data are all 0.
- R2: With byte_mode=1 (register), register number n addresses byte bank_sel*8+n.
- R3: With byte_mode=2 (indirect), the address is the low 7 bits of register reg_num[0] (R0 or R1) of the active bank; bit 7 of the pointer is ignored.
- R4: With byte_mode=0 (direct; code 3 acts the same), byte_addr is used as the address. A read returns that byte on byte_rdata one cycle later.
- R5: A bit address below 80H selects byte 20H+addr[6:3] and bit addr[2:0]. bit_rdata gives that bit's value before the access, one cycle later.
- R6: bit_op codes are 0 read, 1 set, 2 clear and 3 invert. A modifying op changes only the addressed bit of its byte.
- R7: A bit address of 80H or more sets bit_sfr and drives bit_sfr_addr = addr & F8H one cycle later. bit_rdata is 0 and no RAM byte changes. A RAM bit access clears bit_sfr.
- R8: push increments the stack pointer and then writes push_data at the new value. pop returns the byte at the stack pointer on pop_data one cycle later and decrements the pointer.
- R9: A push with the stack pointer at 7FH wraps it to 00H and writes there, and stack_ovf is high for exactly the following cycle.
- R10: Only one RAM write happens per cycle, with priority push over bit write over byte write, and a losing write is discarded. A pop in the same cycle as a push is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bank_sel | input | 2 | Active working-register bank |
| byte_en | input | 1 | Byte port request |
| byte_we | input | 1 | Byte port write (1) or read (0) |
| byte_mode | input | 2 | 0 direct, 1 register, 2 indirect |
| byte_addr | input | 7 | Direct address |
| reg_num | input | 3 | Working register number (bit 0 picks the pointer in indirect mode) |
| byte_wdata | input | 8 | Byte write data |
| byte_rdata | output | 8 | Registered byte read data |
| bit_en | input | 1 | Bit port request |
| bit_op | input | 2 | 0 read, 1 set, 2 clear, 3 invert |
| bit_addr | input | 8 | Bit address |
| bit_rdata | output | 1 | Registered bit value before the access |
| bit_sfr | output | 1 | Last bit access targeted the special-function area |
| bit_sfr_addr | output | 8 | Aligned special-function register address |
| push | input | 1 | Stack push strobe |
| pop | input | 1 | Stack pop strobe |
| push_data | input | 8 | Byte to push |
| pop_data | output | 8 | Registered popped byte |
| sp | output | 7 | Stack pointer |
| stack_ovf | output | 1 | One-cycle pulse after a push from 7FH |

## Verification
The bit port and the byte port can both target the same byte in one cycle. The bench provokes this by setting a bit in byte 2AH while a byte write to 2AH is issued in the same cycle. A following direct read must show only the single set bit, which proves the byte write was discarded. Push and pop are also raised together. The pointer must then advance by one, and the pushed byte must be found at the new pointer value.

// File: rtl/iram_pkg.sv
package iram_pkg;
  localparam int ADDR_W = 7;
  localparam int DATA_W = 8;
  localparam int BANK_W = 2;
  localparam int REG_W  = 3;
  localparam int BITA_W = 8;
  localparam int IDX_W  = 3;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] BIT_BASE = 7'h20;
  localparam logic [ADDR_W-1:0] SP_INIT  = 7'h07;

  localparam logic [1:0] MODE_DIR = 2'd0;
  localparam logic [1:0] MODE_REG = 2'd1;
  localparam logic [1:0] MODE_IND = 2'd2;

  typedef enum logic [1:0] {
    BOP_READ = 2'd0,
    BOP_SET  = 2'd1,
    BOP_CLR  = 2'd2,
    BOP_INV  = 2'd3
  } bit_op_e;
endpackage

// File: rtl/iram_addr_map.sv
module iram_addr_map
  import iram_pkg::*;
(
  input  logic [BANK_W-1:0] bank,
  input  logic [1:0]        mode,
  input  logic [ADDR_W-1:0] dir_addr,
  input  logic [REG_W-1:0]  reg_num,
  input  logic [DATA_W-1:0] ptr_val,
  input  logic [BITA_W-1:0] bit_addr,
  output logic [ADDR_W-1:0] ptr_addr,
  output logic [ADDR_W-1:0] eff_addr,
  output logic [ADDR_W-1:0] bit_byte,
  output logic [IDX_W-1:0]  bit_idx,
  output logic              bit_is_sfr,
  output logic [BITA_W-1:0] sfr_addr
);
  localparam logic [DATA_W-1:0] PTR_MASK = DATA_W'(DEPTH - 1);

  logic [ADDR_W-1:0] reg_addr;

  assign ptr_addr = ADDR_W'({bank, REG_W'(reg_num[0])});
  assign reg_addr = ADDR_W'({bank, reg_num});

  always_comb begin
    case (mode)
      MODE_REG: eff_addr = reg_addr;
      MODE_IND: eff_addr = ADDR_W'(ptr_val & PTR_MASK);
      default:  eff_addr = dir_addr;
    endcase
  end

  assign bit_is_sfr = bit_addr[BITA_W-1];
  assign bit_idx    = bit_addr[IDX_W-1:0];
  assign bit_byte   = BIT_BASE + ADDR_W'(bit_addr[BITA_W-2:IDX_W]);
  assign sfr_addr   = {bit_addr[BITA_W-1:IDX_W], {IDX_W{1'b0}}};
endmodule

// File: rtl/iram_stack_ptr.sv
module iram_stack_ptr
  import iram_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  output logic [ADDR_W-1:0] sp_q,
  output logic [ADDR_W-1:0] push_addr,
  output logic              ovf_q
);
  logic pop_go;

  assign pop_go    = pop & ~push;
  assign push_addr = sp_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q  <= SP_INIT;
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= push & (sp_q == {ADDR_W{1'b1}});
      if (push)        sp_q <= push_addr;
      else if (pop_go) sp_q <= sp_q - 1'b1;
    end
  end

  // R8
  push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> sp_q == $past(sp_q) + 1'b1);
  // R8
  pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> sp_q == $past(sp_q) - 1'b1);
  // R9
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> $past(push) && sp_q == '0);
endmodule

// File: rtl/iram_bank_bit.sv
module iram_bank_bit
  import iram_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  bank_sel,
  input  logic        byte_en,
  input  logic        byte_we,
  input  logic [1:0]  byte_mode,
  input  logic [6:0]  byte_addr,
  input  logic [2:0]  reg_num,
  input  logic [7:0]  byte_wdata,
  output logic [7:0]  byte_rdata,
  input  logic        bit_en,
  input  logic [1:0]  bit_op,
  input  logic [7:0]  bit_addr,
  output logic        bit_rdata,
  output logic        bit_sfr,
  output logic [7:0]  bit_sfr_addr,
  input  logic        push,
  input  logic        pop,
  input  logic [7:0]  push_data,
  output logic [7:0]  pop_data,
  output logic [6:0]  sp,
  output logic        stack_ovf
);
  logic [DATA_W-1:0] mem [DEPTH];

  logic [ADDR_W-1:0] ptr_addr, eff_addr, bit_byte, push_addr;
  logic [IDX_W-1:0]  bit_idx;
  logic              bit_is_sfr;
  logic [BITA_W-1:0] sfr_addr;
  logic [DATA_W-1:0] bit_cur, bit_mod;
  bit_op_e           op;

  logic              pop_go, bit_wr_go, byte_wr_go;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;

  iram_addr_map u_map (
    .bank       (bank_sel),
    .mode       (byte_mode),
    .dir_addr   (byte_addr),
    .reg_num    (reg_num),
    .ptr_val    (mem[ptr_addr]),
    .bit_addr   (bit_addr),
    .ptr_addr   (ptr_addr),
    .eff_addr   (eff_addr),
    .bit_byte   (bit_byte),
    .bit_idx    (bit_idx),
    .bit_is_sfr (bit_is_sfr),
    .sfr_addr   (sfr_addr)
  );

  iram_stack_ptr u_sp (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .pop       (pop),
    .sp_q      (sp),
    .push_addr (push_addr),
    .ovf_q     (stack_ovf)
  );

  assign op      = bit_op_e'(bit_op);
  assign bit_cur = mem[bit_byte];

  always_comb begin
    bit_mod = bit_cur;
    case (op)
      BOP_SET: bit_mod[bit_idx] = 1'b1;
      BOP_CLR: bit_mod[bit_idx] = 1'b0;
      BOP_INV: bit_mod[bit_idx] = ~bit_cur[bit_idx];
      default: bit_mod = bit_cur;
    endcase
  end

  assign pop_go     = pop & ~push;
  assign bit_wr_go  = bit_en & (op != BOP_READ) & ~bit_is_sfr & ~push;
  assign byte_wr_go = byte_en & byte_we & ~push & ~bit_wr_go;

  always_comb begin
    wr_en   = 1'b1;
    wr_addr = eff_addr;
    wr_data = byte_wdata;
    if (push) begin
      wr_addr = push_addr;
      wr_data = push_data;
    end else if (bit_wr_go) begin
      wr_addr = bit_byte;
      wr_data = bit_mod;
    end else if (!byte_wr_go) begin
      wr_en = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_rdata   <= '0;
      bit_rdata    <= 1'b0;
      bit_sfr      <= 1'b0;
      bit_sfr_addr <= '0;
      pop_data     <= '0;
    end else begin
      if (byte_en && !byte_we) byte_rdata <= mem[eff_addr];
      if (bit_en) begin
        bit_sfr      <= bit_is_sfr;
        bit_sfr_addr <= bit_is_sfr ? sfr_addr : '0;
        bit_rdata    <= bit_is_sfr ? 1'b0 : bit_cur[bit_idx];
      end
      if (pop_go) pop_data <= mem[sp];
    end
  end

  // R6
  one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_wr_go |-> $countones(wr_data ^ mem[wr_addr]) <= 1);
  // R7
  sfr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_sfr |-> !bit_rdata);
  // R10
  push_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> wr_en && wr_addr == push_addr && wr_data == push_data);
endmodule

// File: tb/iram_bank_bit_tb.sv
`timescale 1ns/1ps
module iram_bank_bit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bank_sel = '0;
  logic       byte_en = 0, byte_we = 0;
  logic [1:0] byte_mode = '0;
  logic [6:0] byte_addr = '0;
  logic [2:0] reg_num = '0;
  logic [7:0] byte_wdata = '0, byte_rdata;
  logic       bit_en = 0;
  logic [1:0] bit_op = '0;
  logic [7:0] bit_addr = '0;
  logic       bit_rdata, bit_sfr;
  logic [7:0] bit_sfr_addr;
  logic       push = 0, pop = 0;
  logic [7:0] push_data = '0, pop_data;
  logic [6:0] sp;
  logic       stack_ovf;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  iram_bank_bit u_dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    byte_en = 0; byte_we = 0; bit_en = 0; push = 0; pop = 0;
  endtask

  task automatic bwr(input logic [1:0] m, input logic [6:0] a, input logic [2:0] r,
                     input logic [7:0] d);
    byte_en = 1; byte_we = 1; byte_mode = m; byte_addr = a; reg_num = r; byte_wdata = d;
    @(negedge clk); idle();
  endtask

  task automatic brd(input logic [1:0] m, input logic [6:0] a, input logic [2:0] r);
    byte_en = 1; byte_we = 0; byte_mode = m; byte_addr = a; reg_num = r;
    @(negedge clk); idle();
  endtask

  task automatic bitop(input logic [1:0] o, input logic [7:0] a);
    bit_en = 1; bit_op = o; bit_addr = a;
    @(negedge clk); idle();
  endtask

  task automatic do_push(input logic [7:0] d);
    push = 1; push_data = d;
    @(negedge clk); idle();
  endtask

  task automatic do_pop();
    pop = 1;
    @(negedge clk); idle();
  endtask

  task automatic t_reset();
    chk("R1 sp", sp, 7'h07);
    chk("R1 ovf", stack_ovf, 0);
    chk("R1 sfr", bit_sfr, 0);
    chk("R1 bit_rdata", bit_rdata, 0);
    chk("R1 byte_rdata", byte_rdata, 0);
    chk("R1 pop_data", pop_data, 0);
  endtask

  task automatic t_direct();
    bwr(2'd0, 7'h45, 3'd0, 8'hA5);
    brd(2'd0, 7'h45, 3'd0);
    chk("R4 direct read", byte_rdata, 8'hA5);
    bwr(2'd3, 7'h7E, 3'd0, 8'h3C);
    brd(2'd0, 7'h7E, 3'd0);
    chk("R4 mode3 as direct", byte_rdata, 8'h3C);
  endtask

  task automatic t_banks();
    for (int b = 0; b < 4; b++) begin
      bank_sel = 2'(b);
      bwr(2'd1, 7'h00, 3'(b + 3), 8'(8'h10 + b));
    end
    for (int b = 0; b < 4; b++) begin
      brd(2'd0, 7'(b * 8 + b + 3), 3'd0);
      chk("R2 bank map", byte_rdata, 8'h10 + b);
    end
    bank_sel = 2'd2;
    brd(2'd1, 7'h00, 3'd5);
    chk("R2 register read", byte_rdata, 8'h12);
  endtask

  task automatic t_indirect();
    bank_sel = 2'd1;
    bwr(2'd0, 7'h09, 3'd0, 8'hD0);
    bwr(2'd2, 7'h00, 3'd1, 8'h3C);
    brd(2'd0, 7'h50, 3'd0);
    chk("R3 indirect via R1, bit7 ignored", byte_rdata, 8'h3C);
    bwr(2'd0, 7'h08, 3'd0, 8'h51);
    bwr(2'd0, 7'h51, 3'd0, 8'h77);
    brd(2'd2, 7'h00, 3'd0);
    chk("R3 indirect via R0", byte_rdata, 8'h77);
    bank_sel = 2'd0;
  endtask

  task automatic t_bits();
    bwr(2'd0, 7'h24, 3'd0, 8'h00);
    bitop(2'd1, 8'h25);
    chk("R5 prior bit value", bit_rdata, 0);
    brd(2'd0, 7'h24, 3'd0);
    chk("R6 set bit", byte_rdata, 8'h20);
    bitop(2'd0, 8'h25);
    chk("R5 read set bit", bit_rdata, 1);
    bitop(2'd0, 8'h26);
    chk("R5 read clear bit", bit_rdata, 0);
    bitop(2'd3, 8'h27);
    brd(2'd0, 7'h24, 3'd0);
    chk("R6 invert bit", byte_rdata, 8'hA0);
    bitop(2'd2, 8'h25);
    brd(2'd0, 7'h24, 3'd0);
    chk("R6 clear bit", byte_rdata, 8'h80);
    bwr(2'd0, 7'h2F, 3'd0, 8'h00);
    bitop(2'd1, 8'h7F);
    brd(2'd0, 7'h2F, 3'd0);
    chk("R5 top bit address", byte_rdata, 8'h80);
  endtask

  task automatic t_sfr();
    bwr(2'd0, 7'h20, 3'd0, 8'h55);
    bitop(2'd1, 8'hE3);
    chk("R7 sfr flag", bit_sfr, 1);
    chk("R7 sfr addr", bit_sfr_addr, 8'hE0);
    chk("R7 sfr rdata", bit_rdata, 0);
    brd(2'd0, 7'h20, 3'd0);
    chk("R7 ram untouched", byte_rdata, 8'h55);
    bitop(2'd0, 8'h00);
    chk("R7 flag clears", bit_sfr, 0);
    chk("R5 bit 0 of 20H", bit_rdata, 1);
  endtask

  task automatic t_stack();
    do_push(8'h11);
    chk("R8 sp after push", sp, 7'h08);
    do_push(8'h22);
    brd(2'd0, 7'h08, 3'd0);
    chk("R8 push wrote at new sp", byte_rdata, 8'h11);
    do_pop();
    chk("R8 pop data", pop_data, 8'h22);
    chk("R8 sp after pop", sp, 7'h08);
    do_pop();
    chk("R8 second pop", pop_data, 8'h11);
    chk("R8 sp back", sp, 7'h07);
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 120; i++) do_push(8'(i));
    chk("R9 sp at top", sp, 7'h7F);
    chk("R9 no early ovf", stack_ovf, 0);
    do_push(8'hEE);
    chk("R9 sp wraps", sp, 7'h00);
    chk("R9 ovf pulse", stack_ovf, 1);
    brd(2'd0, 7'h00, 3'd0);
    chk("R9 ovf one cycle", stack_ovf, 0);
    chk("R9 wrote at 00H", byte_rdata, 8'hEE);
  endtask

  task automatic t_collide();
    logic [6:0] s;
    bwr(2'd0, 7'h2A, 3'd0, 8'h00);
    byte_en = 1; byte_we = 1; byte_mode = 2'd0; byte_addr = 7'h2A; byte_wdata = 8'hF0;
    bit_en = 1; bit_op = 2'd1; bit_addr = 8'h51;
    @(negedge clk); idle();
    brd(2'd0, 7'h2A, 3'd0);
    chk("R10 bit write beats byte write", byte_rdata, 8'h02);
    s = sp;
    push = 1; pop = 1; push_data = 8'h99;
    @(negedge clk); idle();
    chk("R10 push beats pop", sp, s + 7'd1);
    brd(2'd0, s + 7'd1, 3'd0);
    chk("R10 pushed byte present", byte_rdata, 8'h99);
    bwr(2'd0, 7'h30, 3'd0, 8'h00);
    s = sp;
    push = 1; push_data = 8'h5A;
    byte_en = 1; byte_we = 1; byte_mode = 2'd0; byte_addr = 7'h30; byte_wdata = 8'hFF;
    @(negedge clk); idle();
    brd(2'd0, 7'h30, 3'd0);
    chk("R10 byte write dropped under push", byte_rdata, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_direct();
    t_banks();
    t_indirect();
    t_bits();
    t_sfr();
    t_stack();
    t_wrap();
    t_collide();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule